// File: doc/BRIEF.md
# Multi-Lane Fast-Read Host Sequencer

This block sits on the host side of a serial flash link. It runs the five multi-lane fast-read transfers. A request carries a read-variant code, a 24-bit start address, a mode byte and a byte count. The block sends the command byte on one lane. It then spreads the address and mode bits across one, two or four lanes, as the variant requires, and inserts that variant's don't-care clocks. Finally it rebuilds the returned data into bytes. Those bytes leave the block through a valid/ready handshake.

The serial clock runs at half the system clock. Each lane beat takes one system cycle with the serial clock low and one with it high. Outgoing bits change while the clock is low, and the flash samples them on the rising edge. Incoming data is captured at the end of the high half. When the byte output is still occupied, the block holds the serial clock low before the beat that would complete the next byte. This keeps every byte. A request that cannot be carried out is answered with a one-cycle error flag, and the bus is not touched.

Top module: `mlane_read_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, all four lane drivers are off, no byte is offered, no error is flagged and a request is accepted.
- R2: Every transfer starts with the 8-bit command code, MSB first, on lane 0 only, one bit per serial clock rising edge.
- R3: For variant 1 (dual I/O), each beat carries two address bits and then two mode bits: the odd-numbered bit on lane 1 and the even-numbered bit on lane 0. The order runs from A23/A22 down to M1/M0.
- R4: For variants 3 and 4 (quad I/O), each beat carries one nibble on lanes 3..0. Bit 3 of the nibble goes on lane 3. The order runs from A23..A20 down to A3..A0, then M7..M4, then M3..M0.
- R5: Variants 0 and 2 (dual and quad output) send the address MSB first on lane 0, send no mode byte, and then give 8 don't-care clocks.
- R6: Variant 3 gives 4 don't-care clocks after the mode byte, and variants 1 and 4 give none. The number of serial clock rising edges in a transfer equals the sum of its command, address, mode, dummy and data beats.
- R7: The lane drivers are all off from the first dummy or data beat until chip select rises.
- R8: Data is sampled on the rising serial clock edge. In dual variants (0, 1) a byte arrives as bit pairs with lane 1 holding the higher bit, bits 7/6 first. In quad variants (2, 3, 4) a byte arrives high nibble first.
- R9: A request is rejected in any of three cases: variant 4 with a nonzero address[3:0], a variant code above 4, or a byte count of zero. The rejection raises the error flag in the cycle after acceptance, with no chip select or serial clock activity.
- R10: Without backpressure, chip select stays low for exactly two system cycles per beat and starts low in the cycle after acceptance. Between two transfers it stays high for at least two cycles.
- R11: When the byte consumer stalls, the serial clock pauses. Every requested byte is delivered once, in address order.
- R12: Variant codes 0, 1, 2, 3 and 4 send the command codes 3Bh, BBh, 6Bh, EBh and E3h respectively.
- R13: While a byte is offered and not taken, the offer and its value stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_kind | input | 3 | Read variant code (0..4) |
| req_addr | input | 24 | Start address |
| req_mode | input | 8 | Mode byte for I/O variants |
| req_len | input | 16 | Number of bytes to read |
| req_err | output | 1 | One-cycle flag: request rejected |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| rd_valid | output | 1 | Data byte offered |
| rd_ready | input | 1 | Data byte taken |
| rd_data | output | 8 | Data byte |

## Verification
The error flag is due at the first falling clock edge after the accepting rising edge. At that same falling edge, a good request must already show chip select low with the serial clock low, and the first serial clock rise follows one cycle later. The bench keeps a behavioural flash model. It counts serial clock rises at every falling system clock edge and, for each rise, computes the exact lane values and enables that beat should carry. It also presents each returned data beat during the preceding low half, so the value is steady when the rising edge samples it. A byte is checked when it is handed over. The low time of chip select, 2 cycles per computed beat, is checked when chip select rises, but only in phases without backpressure.

// File: rtl/mlane_pkg.sv
package mlane_pkg;

    typedef enum logic [2:0] {
        K_DOUT = 3'd0,
        K_DIO  = 3'd1,
        K_QOUT = 3'd2,
        K_QIO  = 3'd3,
        K_OCTW = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_GAP
    } phase_e;

    function automatic logic f_kind_ok(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic [7:0] f_opcode(input logic [2:0] k);
        case (k)
            K_DOUT:  return 8'h3B;
            K_DIO:   return 8'hBB;
            K_QOUT:  return 8'h6B;
            K_QIO:   return 8'hEB;
            K_OCTW:  return 8'hE3;
            default: return 8'h00;
        endcase
    endfunction

    // lanes used for address and mode
    function automatic logic [2:0] f_alanes(input logic [2:0] k);
        case (k)
            K_DIO:         return 3'd2;
            K_QIO, K_OCTW: return 3'd4;
            default:       return 3'd1;
        endcase
    endfunction

    // lanes used for returned data
    function automatic logic [2:0] f_dlanes(input logic [2:0] k);
        case (k)
            K_DOUT, K_DIO: return 3'd2;
            default:       return 3'd4;
        endcase
    endfunction

    function automatic logic f_has_mode(input logic [2:0] k);
        return (k == K_DIO) || (k == K_QIO) || (k == K_OCTW);
    endfunction

    // don't-care serial clocks before data
    function automatic logic [3:0] f_dummy(input logic [2:0] k);
        case (k)
            K_DOUT, K_QOUT: return 4'd8;
            K_QIO:          return 4'd4;
            default:        return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/mlane_tx.sv
module mlane_tx
    import mlane_pkg::*;
(
    input  phase_e     ph,
    input  logic [2:0] alanes,
    input  logic [3:0] top_bits,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic [2:0] lanes
);

    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        lanes  = 3'd1;
        case (ph)
            PH_CMD: begin
                io_oe  = 4'b0001;
                io_out = {3'b000, top_bits[3]};
            end
            PH_ADDR, PH_MODE: begin
                lanes = alanes;
                case (alanes)
                    3'd2: begin
                        io_oe  = 4'b0011;
                        io_out = {2'b00, top_bits[3:2]};
                    end
                    3'd4: begin
                        io_oe  = 4'b1111;
                        io_out = top_bits;
                    end
                    default: begin
                        io_oe  = 4'b0001;
                        io_out = {3'b000, top_bits[3]};
                    end
                endcase
            end
            default: begin
                io_oe  = 4'b0000;
                io_out = 4'b0000;
            end
        endcase
    end

endmodule

// File: rtl/mlane_rx.sv
module mlane_rx
    import mlane_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap,
    input  logic       last,
    input  logic [2:0] lanes,
    input  logic [3:0] io_in,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data
);

    typedef struct packed {
        logic [7:0] acc;
        logic [7:0] hold;
        logic       vld;
    } rx_t;

    rx_t        r_q, r_d;
    logic [7:0] acc_nx;

    always_comb begin
        acc_nx = (lanes == 3'd4) ? {r_q.acc[3:0], io_in}
                                 : {r_q.acc[5:0], io_in[1:0]};
        r_d = r_q;
        if (r_q.vld && rd_ready) begin
            r_d.vld = 1'b0;
        end
        if (cap) begin
            r_d.acc = acc_nx;
            if (last) begin
                r_d.hold = acc_nx;
                r_d.vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_valid = r_q.vld;
    assign rd_data  = r_q.hold;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R13

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && last) |-> !(rd_valid && !rd_ready)); // R11

endmodule

// File: rtl/mlane_read_seq.sv
module mlane_read_seq
    import mlane_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LEN_W   = 16,
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_mode,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_err,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data
);

    localparam int SH_W  = 8 + ADDR_W + 8;
    localparam int CNT_W = $clog2(ADDR_W + 1) + 1;
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

    typedef struct packed {
        phase_e            ph;
        logic              sck;
        logic [SH_W-1:0]   sh;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        kind;
        logic [LEN_W-1:0]  left;
        logic              err;
    } seq_t;

    seq_t s_q, s_d;

    logic [2:0]       alanes, dlanes, lanes;
    logic [3:0]       dummy;
    logic             has_mode, req_bad, active, cap, last, stall;
    logic [CNT_W-1:0] addr_last, mode_last, data_last;
    phase_e           ph_after_mode, ph_after_addr;
    logic [CNT_W-1:0] cnt_after_mode, cnt_after_addr;

    assign alanes   = f_alanes(s_q.kind);
    assign dlanes   = f_dlanes(s_q.kind);
    assign dummy    = f_dummy(s_q.kind);
    assign has_mode = f_has_mode(s_q.kind);

    assign req_bad = !f_kind_ok(req_kind) || (req_len == '0) ||
                     ((req_kind == K_OCTW) && (req_addr[3:0] != 4'h0));

    assign active = (s_q.ph == PH_CMD) || (s_q.ph == PH_ADDR) ||
                    (s_q.ph == PH_MODE) || (s_q.ph == PH_DUMMY) ||
                    (s_q.ph == PH_DATA);

    assign cap   = (s_q.ph == PH_DATA) && s_q.sck;
    assign last  = (s_q.cnt == '0);
    assign stall = (s_q.ph == PH_DATA) && !s_q.sck && (s_q.cnt == '0) &&
                   rd_valid && !rd_ready;

    // beat counts (minus one) per phase for the selected variant
    always_comb begin
        case (alanes)
            3'd2:    begin addr_last = CNT_W'(ADDR_W / 2 - 1); mode_last = CNT_W'(3); end
            3'd4:    begin addr_last = CNT_W'(ADDR_W / 4 - 1); mode_last = CNT_W'(1); end
            default: begin addr_last = CNT_W'(ADDR_W - 1);     mode_last = CNT_W'(7); end
        endcase
        data_last = (dlanes == 3'd4) ? CNT_W'(1) : CNT_W'(3);

        if (dummy != 4'd0) begin
            ph_after_mode  = PH_DUMMY;
            cnt_after_mode = CNT_W'(dummy) - CNT_W'(1);
        end else begin
            ph_after_mode  = PH_DATA;
            cnt_after_mode = data_last;
        end
        if (has_mode) begin
            ph_after_addr  = PH_MODE;
            cnt_after_addr = mode_last;
        end else begin
            ph_after_addr  = ph_after_mode;
            cnt_after_addr = cnt_after_mode;
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                s_d.sck = 1'b0;
                if (req_valid) begin
                    if (req_bad) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.ph   = PH_CMD;
                        s_d.cnt  = CMD_LAST;
                        s_d.sh   = {f_opcode(req_kind), req_addr, req_mode};
                        s_d.kind = req_kind;
                        s_d.left = req_len;
                    end
                end
            end
            PH_GAP: begin
                s_d.sck = 1'b0;
                if (s_q.cnt == '0) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (!s_q.sck) begin
                    if (!stall) begin
                        s_d.sck = 1'b1;
                    end
                end else begin
                    s_d.sck = 1'b0;
                    if ((s_q.ph == PH_CMD) || (s_q.ph == PH_ADDR) || (s_q.ph == PH_MODE)) begin
                        s_d.sh = s_q.sh << lanes;
                    end
                    if (s_q.cnt != '0) begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end else begin
                        case (s_q.ph)
                            PH_CMD: begin
                                s_d.ph  = PH_ADDR;
                                s_d.cnt = addr_last;
                            end
                            PH_ADDR: begin
                                s_d.ph  = ph_after_addr;
                                s_d.cnt = cnt_after_addr;
                            end
                            PH_MODE: begin
                                s_d.ph  = ph_after_mode;
                                s_d.cnt = cnt_after_mode;
                            end
                            PH_DUMMY: begin
                                s_d.ph  = PH_DATA;
                                s_d.cnt = data_last;
                            end
                            default: begin
                                s_d.left = s_q.left - LEN_W'(1);
                                if (s_q.left == LEN_W'(1)) begin
                                    s_d.ph  = PH_GAP;
                                    s_d.cnt = GAP_LAST;
                                end else begin
                                    s_d.cnt = data_last;
                                end
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    mlane_tx u_tx (
        .ph       (s_q.ph),
        .alanes   (alanes),
        .top_bits (s_q.sh[SH_W-1 -: 4]),
        .io_out   (io_out),
        .io_oe    (io_oe),
        .lanes    (lanes)
    );

    mlane_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .last     (last),
        .lanes    (dlanes),
        .io_in    (io_in),
        .rd_ready (rd_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign req_ready = (s_q.ph == PH_IDLE);
    assign req_err   = s_q.err;
    assign spi_cs_n  = !active;
    assign spi_sck   = s_q.sck;

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n); // R10

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (spi_cs_n && !spi_sck)); // R9

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (io_oe == 4'b0000)); // R7

    AST_OPCODE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_CMD) |-> (io_oe == 4'b0001)); // R2

endmodule

// File: tb/mlane_read_seq_bench.sv
module mlane_read_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_mode = '0;
    logic [15:0] req_len = '0;
    logic        req_err;
    logic        spi_cs_n, spi_sck;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = 4'h0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;

    always #5 clk = ~clk;

    mlane_read_seq u_mlane_read_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_mode(req_mode),
        .req_len(req_len), .req_err(req_err), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    int vectors = 0;
    int errors  = 0;
    bit mon_on  = 0;
    bit bp_mode = 0;
    bit done    = 0;

    int cur_kind, cur_addr, cur_mode, cur_len;
    int rises = 0, low_cnt = 0, high_cnt = 0;
    bit seen_txn = 0;
    logic prev_sck = 1'b0, prev_cs = 1'b1, prev_hold = 1'b0;
    logic [7:0] prev_data = '0;
    logic [7:0] exp_q[$];

    function automatic int f_al(int k);
        case (k) 1: return 2; 3, 4: return 4; default: return 1; endcase
    endfunction
    function automatic int f_dl(int k);
        return (k <= 1) ? 2 : 4;
    endfunction
    function automatic int f_hm(int k);
        return (k == 1 || k == 3 || k == 4) ? 1 : 0;
    endfunction
    function automatic int f_dm(int k);
        case (k) 0, 2: return 8; 3: return 4; default: return 0; endcase
    endfunction
    function automatic int f_op(int k);
        case (k) 0: return 'h3B; 1: return 'hBB; 2: return 'h6B; 3: return 'hEB; default: return 'hE3; endcase
    endfunction
    function automatic int f_pre(int k);
        return 8 + 24 / f_al(k) + f_hm(k) * (8 / f_al(k)) + f_dm(k);
    endfunction
    function automatic int f_total(int k, int n);
        return f_pre(k) + n * (8 / f_dl(k));
    endfunction
    function automatic logic [7:0] f_byte(int a, int i);
        return 8'(((a + i) * 37) ^ 'hC3);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic beat_check(int r);
        int a, m, b, v;
        string tag;
        a = f_al(cur_kind);
        m = (1 << a) - 1;
        tag = (a == 1) ? "R5" : ((a == 2) ? "R3" : "R4");
        if (r < 8) begin
            v = (f_op(cur_kind) >> (7 - r)) & 1;
            chk(io_oe == 4'b0001 && int'(io_out[0]) == v, "R2 R12 command beat",
                {io_oe, io_out}, {4'b0001, 4'(v)});
        end else if (r < 8 + 24 / a) begin
            b = r - 8;
            v = (cur_addr >> (24 - a * (b + 1))) & m;
            chk(int'(io_oe) == m && (int'(io_out) & m) == v, {tag, " address beat"},
                {io_oe, io_out}, {4'(m), 4'(v)});
        end else if (f_hm(cur_kind) == 1 && r < 8 + 32 / a) begin
            b = r - 8 - 24 / a;
            v = (cur_mode >> (8 - a * (b + 1))) & m;
            chk(int'(io_oe) == m && (int'(io_out) & m) == v, {tag, " mode beat"},
                {io_oe, io_out}, {4'(m), 4'(v)});
        end else begin
            chk(io_oe == 4'b0000, "R7 drivers released", io_oe, 0);
        end
    endtask

    // rd_ready changes away from both clock edges
    always @(posedge clk) begin
        #2;
        rd_ready = bp_mode ? ($urandom_range(0, 7) >= 3) : 1'b1;
    end

    // behavioural flash model and monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (spi_sck && !prev_sck) begin
                beat_check(rises);
                rises++;
            end
            if (!spi_cs_n && !spi_sck) begin
                int ds, d, per, part;
                logic [7:0] by;
                ds = f_pre(cur_kind);
                if (rises >= ds) begin
                    d = rises - ds;
                    per = 8 / f_dl(cur_kind);
                    part = d % per;
                    by = f_byte(cur_addr, d / per);
                    if (f_dl(cur_kind) == 2) io_in = {2'b00, 2'(by >> (6 - 2 * part))};
                    else                     io_in = 4'(by >> (4 - 4 * part));
                end else begin
                    io_in = 4'h9;
                end
            end
            if (!spi_cs_n) begin
                if (prev_cs && seen_txn)
                    chk(high_cnt >= 2, "R10 chip select idle gap", high_cnt, 2);
                low_cnt++;
            end else begin
                if (!prev_cs) begin
                    if (!bp_mode)
                        chk(low_cnt == 2 * f_total(cur_kind, cur_len), "R10 select low time",
                            low_cnt, 2 * f_total(cur_kind, cur_len));
                    chk(rises == f_total(cur_kind, cur_len), "R6 serial clock count",
                        rises, f_total(cur_kind, cur_len));
                    rises = 0;
                    low_cnt = 0;
                    high_cnt = 0;
                    seen_txn = 1;
                end
                high_cnt++;
            end
            if (prev_hold)
                chk(rd_valid && rd_data == prev_data, "R13 held byte", {rd_valid, rd_data}, {1'b1, prev_data});
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R11 unexpected byte", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, bp_mode ? "R11 byte under stall" : "R8 byte value", rd_data, e);
                end
            end
            prev_hold = rd_valid && !rd_ready;
            prev_data = rd_data;
            prev_sck  = spi_sck;
            prev_cs   = spi_cs_n;
        end
    end

    task automatic send(int k, int a, int md, int n, bit bad);
        @(negedge clk);
        req_kind = 3'(k); req_addr = 24'(a); req_mode = 8'(md); req_len = 16'(n);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        if (!bad) begin
            cur_kind = k; cur_addr = a; cur_mode = md; cur_len = n;
            for (int i = 0; i < n; i++) exp_q.push_back(f_byte(a, i));
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err == bad, "R9 error flag", req_err, bad);
        if (bad) begin
            for (int i = 0; i < 5; i++) begin
                chk(spi_cs_n && !spi_sck, "R9 bus quiet", {spi_cs_n, spi_sck}, 2);
                @(negedge clk);
            end
        end else begin
            chk(!spi_cs_n && !spi_sck, "R10 select start", {spi_cs_n, spi_sck}, 0);
        end
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!(req_ready && exp_q.size() == 0 && !rd_valid));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 reset select", spi_cs_n, 1);
        chk(spi_sck == 1'b0 && io_oe == 4'b0000, "R1 reset bus", {spi_sck, io_oe}, 0);
        chk(rd_valid == 1'b0 && req_err == 1'b0, "R1 reset outputs", {rd_valid, req_err}, 0);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        mon_on = 1;

        send(0, 'h123456, 'h00, 3, 0);  wait_done();   // R5 R8 R12
        send(1, 'hA5C3F0, 'h5A, 2, 0);  wait_done();   // R3
        send(2, 'h7FFFFF, 'h00, 2, 0);  wait_done();   // R5
        send(3, 'h3C96E1, 'hA5, 4, 0);  wait_done();   // R4 R6
        send(4, 'h000120, 'h20, 16, 0); wait_done();   // R6
        send(4, 'h000123, 'h20, 4, 1);                 // R9 misaligned
        send(5, 'h000000, 'h00, 4, 1);                 // R9 bad variant
        send(1, 'h001000, 'h00, 0, 1);                 // R9 zero count
        send(3, 'h0F0F00, 'hF0, 3, 0);                 // R10 back to back
        send(1, 'hFFFFFE, 'h3C, 3, 0);  wait_done();
        bp_mode = 1;                                    // R11 R13
        send(3, 'h246800, 'h11, 8, 0);
        send(0, 'h13579B, 'h00, 5, 0);
        send(4, 'h0ABC00, 'h99, 6, 0);  wait_done();
        bp_mode = 0;
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all bytes delivered", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule